// File: doc/BRIEF.md
# Dual Prescaled Reload Timer Unit

The unit holds two independent 32-bit down-counters. Each counter is paced by its own prescaler, which divides the system clock by a programmable ratio. The first timer is a real-time clock timer with an 8-bit prescaler. The second is a general-purpose timer with a 16-bit prescaler. Every time a prescaler expires, its counter is examined. A nonzero counter steps down by one. A counter at zero raises a one-cycle interrupt pulse, and then either refills from its reload value or halts, depending on the mode.

Software reaches the unit through a small word-wide register port. Each timer has a counter/reload location and a scaler location, and one shared control word serves both timers. A write to a counter location sets only the reload value; the control word copies that value into the counter. The control word also selects the refill mode and starts or stops each timer. A start/stop request is applied only when its strobe bit is set in the same word. Reading a scaler location returns the programmed value while the timer is idle, and the prescale count still remaining while it runs. Writes that carry bits a location cannot hold raise an error pulse.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, both counter locations read 0xFFFFFFFF, both scaler locations read 0, and `rtc_irq`, `gpt_irq` and `wr_err` are low.
- R2: The address map is: 0 real-time counter/reload, 1 real-time scaler, 2 general counter/reload, 3 general scaler, 4 control. The real-time scaler keeps bits 7:0 and the general scaler keeps bits 15:0. A scaler write with any higher bit set stores the low bits and drives `wr_err` high for the one cycle after the write.
- R3: A control write with any bit set outside 11:8 and 3:0 drives `wr_err` high for the one cycle after the write. A control write inside those bits leaves `wr_err` low. Reading the control location returns 0.
- R4: A write to a counter location changes only the reload value, so the counter reads back unchanged. A control write with the load bit set (bit 9 for the real-time timer, bit 1 for the general timer) copies the reload value into the counter.
- R5: A control write with both the strobe bit (11 / 3) and the enable bit (10 / 2) set starts a stopped timer. The prescaler period is the scaler value + 1 clocks, and each expiry steps a nonzero counter down by one.
- R6: An expiry that finds the counter at zero raises the timer's interrupt as a single-cycle pulse. With the continuous bit (8 / 0) set, the counter refills from the reload value. With scaler S and counter C loaded, the first pulse follows the starting edge by (S+1)(C+1) clocks.
- R7: With the continuous bit clear, the timer halts after its pulse. The counter stays at 0 and no further pulse follows.
- R8: An enable bit written without its strobe bit has no effect. A stopped timer stays stopped and its counter is unchanged.
- R9: A strobed control write with the enable bit clear stops a running timer at its next prescaler expiry. That expiry does not change the counter, and the value is held.
- R10: While a timer runs, its scaler location reads the scaler value minus the clocks already spent in the current prescale period.
- R11: The two timers are independent. Running, loading or stopping one leaves the other's counter and interrupt untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 3 | Register select (see R2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register, combinational |
| wr_err | output | 1 | One-cycle pulse after an illegal-bit write |
| rtc_irq | output | 1 | Real-time timer interrupt pulse |
| gpt_irq | output | 1 | General-purpose timer interrupt pulse |

## Verification
The bench measures the exact edge on which the first and the second interrupt pulses appear. An off-by-one in the prescale period or in the zero test moves the pulse by whole periods, and a refill that goes wrong shifts the second pulse. It checks that the counter is held when a strobed stop lands between expiries; a design that ignored the strobe, or stopped at once, would let the counter decay to an interrupt. It also checks that an enable without a strobe is ignored, that a one-shot timer stays at zero, and that a counter-location write leaves the live counter alone. A design that merged reload and counter, or honoured the bare enable, would show a different counter value.

// File: rtl/timer_pkg.sv
// Shared types and helpers for the dual prescaled reload timer.
// Assumes at most two timers; the control nibble of timer 0 sits at bits 11:8,
// every other timer's nibble at bits 3:0 (only two timers are ever built).
package timer_pkg;

    // Per-timer control nibble, MSB first: strobe, enable, load, continuous.
    typedef struct packed {
        logic strobe;
        logic en;
        logic load;
        logic cont;
    } tmr_ctrl_t;

    // Bit offset of a timer's nibble inside the shared control word.
    function automatic int ctrl_base(input int idx);
        return (idx == 0) ? 8 : 0;
    endfunction

    // Mask of the control-word bits that some timer owns.
    function automatic logic [31:0] ctrl_legal(input int ntmr);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < ntmr; i++) m |= 32'hF << ctrl_base(i);
        return m;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
// Register write decoder: turns one write port into per-timer strobes and
// splits the shared control word into per-timer nibbles.
// Assumes addresses 2*i and 2*i+1 belong to timer i and 2*NTMR is control.
module tmr_regdec
    import timer_pkg::*;
#(
    parameter int NTMR   = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NTMR-1:0]   wr_cnt,
    output logic [NTMR-1:0]   wr_scl,
    output logic              ctrl_wr,
    output tmr_ctrl_t         ctrl [NTMR],
    output logic              ctrl_err
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NTMR);
    localparam logic [DATA_W-1:0] LEGAL     = DATA_W'(ctrl_legal(NTMR));

    // Control write strobe and illegal-bit detection.
    assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
    assign ctrl_err = ctrl_wr && |(wdata & ~LEGAL);

    for (genvar g = 0; g < NTMR; g++) begin : g_dec
        // Per-timer counter/scaler strobes and control nibble extraction.
        assign wr_cnt[g] = wr_en && (addr == ADDR_W'(2 * g));
        assign wr_scl[g] = wr_en && (addr == ADDR_W'(2 * g + 1));
        assign ctrl[g]   = tmr_ctrl_t'(wdata[ctrl_base(g) +: 4]);
    end

endmodule

// File: rtl/tmr_prescaler.sv
// Programmable prescaler: counts down from the scaler value and flags an
// expiry when it reaches zero, so one period is scaler + 1 clocks.
// Assumes start and run are never both needed: start reloads the count.
module tmr_prescaler #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [SW-1:0] scaler,
    output logic          expire,
    output logic [SW-1:0] remain
);
    logic [SW-1:0] cnt_q;

    // Down-count the prescale value, refilling on start or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= scaler;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? scaler : cnt_q - 1'b1;
        end
    end

    assign expire = run && !start && (cnt_q == '0);
    assign remain = cnt_q;

endmodule

// File: rtl/tmr_channel.sv
// One timer: scaler, reload and counter registers, run state and interrupt.
// Assumes the control nibble is valid only in cycles where ctrl_wr is high.
module tmr_channel
    import timer_pkg::*;
#(
    parameter int SW     = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cnt,
    input  logic              wr_scl,
    input  logic              ctrl_wr,
    input  tmr_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_rd,
    output logic [DATA_W-1:0] scl_rd,
    output logic              irq,
    output logic              scl_err
);
    localparam logic [DATA_W-1:0] KEEP = (DATA_W'(1) << SW) - 1'b1;

    logic [DATA_W-1:0] cnt_q, reload_q;
    logic [SW-1:0]     scl_q, remain;
    logic              run_q, en_q, cont_q, irq_q;
    logic              start, expire;

    assign start   = ctrl_wr && ctrl.strobe && ctrl.en && !run_q;
    assign scl_err = wr_scl && |(wdata & ~KEEP);

    tmr_prescaler #(.SW(SW)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run_q),
        .scaler (scl_q),
        .expire (expire),
        .remain (remain)
    );

    // Register writes, expiry handling and interrupt pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '1;
            reload_q <= '1;
            scl_q    <= '0;
            run_q    <= 1'b0;
            en_q     <= 1'b0;
            cont_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_cnt) reload_q <= wdata;
            if (wr_scl) scl_q    <= wdata[SW-1:0];
            if (expire) begin
                if (!en_q) begin
                    run_q <= 1'b0;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    irq_q <= 1'b1;
                    if (cont_q) begin
                        cnt_q <= reload_q;
                    end else begin
                        run_q <= 1'b0;
                        en_q  <= 1'b0;
                    end
                end
            end
            if (ctrl_wr) begin
                cont_q <= ctrl.cont;
                if (ctrl.strobe) en_q <= ctrl.en;
                if (start)       run_q <= 1'b1;
                if (ctrl.load)   cnt_q <= reload_q;
            end
        end
    end

    assign cnt_rd = cnt_q;
    assign scl_rd = run_q ? DATA_W'(remain) : DATA_W'(scl_q);
    assign irq    = irq_q;

endmodule

// File: rtl/dual_reload_timer.sv
// Top of the dual prescaled reload timer: a real-time timer with a narrow
// prescaler and a general timer with a wide one behind one register port.
// Assumes single-cycle writes; reads are combinational from addr.
module dual_reload_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    parameter int RTC_SCL_W = 8,
    parameter int GPT_SCL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_err,
    output logic              rtc_irq,
    output logic              gpt_irq
);
    localparam int NTMR = 2;

    logic [NTMR-1:0]   wr_cnt, wr_scl, irq, scl_err;
    logic              ctrl_wr, ctrl_err, err_q;
    tmr_ctrl_t         ctrl [NTMR];
    logic [DATA_W-1:0] cnt_rd [NTMR];
    logic [DATA_W-1:0] scl_rd [NTMR];

    tmr_regdec #(.NTMR(NTMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .wr_cnt   (wr_cnt),
        .wr_scl   (wr_scl),
        .ctrl_wr  (ctrl_wr),
        .ctrl     (ctrl),
        .ctrl_err (ctrl_err)
    );

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam int SW = (g == 0) ? RTC_SCL_W : GPT_SCL_W;
        tmr_channel #(.SW(SW), .DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cnt  (wr_cnt[g]),
            .wr_scl  (wr_scl[g]),
            .ctrl_wr (ctrl_wr),
            .ctrl    (ctrl[g]),
            .wdata   (wdata),
            .cnt_rd  (cnt_rd[g]),
            .scl_rd  (scl_rd[g]),
            .irq     (irq[g]),
            .scl_err (scl_err[g])
        );
    end

    // Register the illegal-write indication as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= ctrl_err || |scl_err;
    end

    // Read multiplexer: even addresses counters, odd scalers, others zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NTMR; i++) begin
            if (addr == ADDR_W'(2 * i))     rdata = cnt_rd[i];
            if (addr == ADDR_W'(2 * i + 1)) rdata = scl_rd[i];
        end
    end

    assign wr_err  = err_q;
    assign rtc_irq = irq[0];
    assign gpt_irq = irq[1];

endmodule

// File: rtl/dual_reload_timer_chk.sv
// Property checker for the dual reload timer, bound to the top module.
// Assumes the default address map (0..3 timer registers, 4 control).
module dual_reload_timer_chk #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    parameter int RTC_SCL_W = 8,
    parameter int GPT_SCL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              wr_err
);
    // R3: a control write outside the owned nibbles raises the error pulse.
    p_ctrl_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4) && |(wdata & ~DATA_W'(32'h0F0F))) |=> wr_err);

    // R2: an oversized real-time scaler write raises the error pulse.
    p_rtc_scl_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1) && |(wdata >> RTC_SCL_W)) |=> wr_err);

    // R2: an oversized general scaler write raises the error pulse.
    p_gpt_scl_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(3) && |(wdata >> GPT_SCL_W)) |=> wr_err);

    // R3: without a write there is no error pulse in the next cycle.
    p_no_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    // R10: a real-time scaler read never exceeds its width.
    p_rtc_scl_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(1)) |-> ((rdata >> RTC_SCL_W) == '0));

    // R10: a general scaler read never exceeds its width.
    p_gpt_scl_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(3)) |-> ((rdata >> GPT_SCL_W) == '0));
endmodule

bind dual_reload_timer dual_reload_timer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RTC_SCL_W(RTC_SCL_W), .GPT_SCL_W(GPT_SCL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wr_err(wr_err)
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
    localparam logic [2:0] A_RCNT = 3'd0, A_RSCL = 3'd1, A_GCNT = 3'd2,
                           A_GSCL = 3'd3, A_CTRL = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wr_err, rtc_irq, gpt_irq;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    dual_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wr_err(wr_err), .rtc_irq(rtc_irq), .gpt_irq(gpt_irq)
    );

    // Register-port vectors: {addr, wdata, expected wr_err, expected readback}.
    localparam logic [67:0] VEC [9] = '{
        {A_RSCL, 32'h0000_00AB, 1'b0, 32'h0000_00AB},   // R2 fits
        {A_RSCL, 32'h0000_0155, 1'b1, 32'h0000_0055},   // R2 oversize
        {A_GSCL, 32'h0001_2345, 1'b1, 32'h0000_2345},   // R2 oversize
        {A_GSCL, 32'h0000_BEEF, 1'b0, 32'h0000_BEEF},   // R2 fits
        {A_RCNT, 32'h1234_5678, 1'b0, 32'hFFFF_FFFF},   // R4 reload only
        {A_CTRL, 32'h0000_1000, 1'b1, 32'h0000_0000},   // R3 bit 12
        {A_CTRL, 32'h0000_0010, 1'b1, 32'h0000_0000},   // R3 bit 4
        {A_CTRL, 32'h0000_0000, 1'b0, 32'h0000_0000},   // R3 legal
        {A_GCNT, 32'h0000_00AA, 1'b0, 32'hFFFF_FFFF}    // R4 reload only
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // Count negedges from the current one until the chosen interrupt shows.
    task automatic wait_irq(input bit use_gpt, inout int n);
        while (!(use_gpt ? gpt_irq : rtc_irq) && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_RCNT, v); chk("R1 rtc counter", v, 32'hFFFF_FFFF);
        rd(A_GCNT, v); chk("R1 gpt counter", v, 32'hFFFF_FFFF);
        rd(A_RSCL, v); chk("R1 rtc scaler", v, 0);
        rd(A_GSCL, v); chk("R1 gpt scaler", v, 0);
        chk("R1 irqs/err", {29'd0, rtc_irq, gpt_irq, wr_err}, 0);

        // Vector table walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][67:65], VEC[i][64:33]);
            chk($sformatf("R2/R3/R4 vec%0d err", i), {31'd0, wr_err}, {31'd0, VEC[i][32]});
            rd(VEC[i][67:65], v);
            chk($sformatf("R2/R3/R4 vec%0d read", i), v, VEC[i][31:0]);
        end

        // R4: load bits copy reload into counters
        wr(A_CTRL, 32'h0000_0202);
        rd(A_RCNT, v); chk("R4 rtc load", v, 32'h1234_5678);
        rd(A_GCNT, v); chk("R4 gpt load", v, 32'h0000_00AA);

        // R5 R6 R10: real-time timer, scaler 3, counter 2, continuous
        wr(A_RSCL, 3); wr(A_RCNT, 2); wr(A_CTRL, 32'h0000_0200);
        rd(A_RCNT, v); chk("R4 rtc counter loaded", v, 2);
        wr(A_CTRL, 32'h0000_0D00);
        rd(A_RSCL, v); chk("R10 remain at start", v, 3);
        @(negedge clk);
        rd(A_RSCL, v); chk("R10 remain after one clock", v, 2);
        n = 1;
        wait_irq(1'b0, n);
        chk("R5 R6 first pulse edge", n, 12);
        @(negedge clk); n++;
        chk("R6 pulse width", {31'd0, rtc_irq}, 0);
        rd(A_RCNT, v); chk("R6 continuous refill", v, 2);
        wait_irq(1'b0, n);
        chk("R6 second pulse edge", n, 24);
        @(negedge clk);

        // R9: strobed stop between expiries holds the counter
        wr(A_CTRL, 32'h0000_0800);
        seen = 0;
        repeat (40) begin @(negedge clk); if (rtc_irq) seen = 1; end
        chk("R9 no pulse after stop", {31'd0, seen}, 0);
        rd(A_RCNT, v); chk("R9 counter held", v, 2);
        rd(A_RSCL, v); chk("R9 stopped scaler reads value", v, 3);

        // R8: enable without strobe is ignored
        wr(A_GSCL, 1); wr(A_GCNT, 5); wr(A_CTRL, 32'h0000_0002);
        wr(A_CTRL, 32'h0000_0004);
        seen = 0;
        repeat (20) begin @(negedge clk); if (gpt_irq) seen = 1; end
        rd(A_GCNT, v); chk("R8 counter unchanged", v, 5);
        chk("R8 no pulse", {31'd0, seen}, 0);

        // R7: one-shot general timer, scaler 1, counter 1
        wr(A_GCNT, 1); wr(A_CTRL, 32'h0000_0002);
        wr(A_CTRL, 32'h0000_000C);
        n = 0;
        wait_irq(1'b1, n);
        chk("R7 one-shot pulse edge", n, 4);
        seen = 0;
        repeat (20) begin @(negedge clk); if (gpt_irq || rtc_irq) seen = 1; end
        chk("R7 R11 no further pulse", {31'd0, seen}, 0);
        rd(A_GCNT, v); chk("R7 counter stays zero", v, 0);
        rd(A_GSCL, v); chk("R7 halted scaler reads value", v, 1);
        rd(A_RCNT, v); chk("R11 other counter untouched", v, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule